// File: doc/BRIEF.md
# Supply-Drop Reset Controller

This block decides when a low-supply indication may reset the chip, and it produces a stretched system reset. An external comparator supplies a synchronous flag that is high while the supply is below the trip level. The comparison has no hysteresis band, so the flag is used exactly as it arrives. An enable pin, the CPU's power-down state and an arm latch together decide whether a low-supply indication counts. The arm latch is set by a decoded instruction.

Two state latches are kept. The power-down latch is set when a power-down prefix strobe is followed, in the very next cycle, by either of the two power-down instruction strobes. A timer wake, a key-on wake or the internal reset clears it. The arm latch is set by the arm strobe and cleared only by the internal reset. A qualified drop asserts the reset. After the drop ends, the reset is held for a fixed number of oscillator cycles. The default count, 5412, sits in the middle of the permitted 5400 to 5424 window.

Top module: `svr_reset_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `sys_reset_o`=1, `pd_mode_o`=0 and `armed_o`=0. After `rst_n` goes high with no qualified drop, `sys_reset_o` stays 1 for exactly RELEASE_COUNT cycles and then goes to 0.
- R2: With `enable_i`=0, `drop_i`=1 never asserts `sys_reset_o`, in running mode or in power-down, armed or not.
- R3: With `enable_i`=1 and `pd_mode_o`=0, `drop_i`=1 at a clock edge makes `sys_reset_o`=1 in the next cycle.
- R4: With `pd_mode_o`=1 and `armed_o`=0, `drop_i`=1 is ignored even with `enable_i`=1. `sys_reset_o` stays 0.
- R5: With `pd_mode_o`=1, `armed_o`=1 and `enable_i`=1, `drop_i`=1 makes `sys_reset_o`=1 in the next cycle.
- R6: `arm_stb_i` sets `armed_o` in the next cycle. Timer and key wakes do not clear it. Only the internal reset clears it.
- R7: `pd_a_stb_i` or `pd_b_stb_i` sets `pd_mode_o` in the next cycle only when `pd_prefix_stb_i` was high in the cycle just before. A power-down strobe alone, or one that comes two or more cycles after the prefix, leaves `pd_mode_o` at 0.
- R8: `timer_wake_i` or `key_wake_i` clears `pd_mode_o` in the next cycle. A clear wins over a set that falls in the same cycle.
- R9: After the last cycle with a qualified drop, `sys_reset_o` stays 1 for exactly RELEASE_COUNT cycles. A qualified drop seen during that window restarts the full count.
- R10: While `sys_reset_o` is 1, both latches and the prefix pending flag are held cleared. Strobes given in that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | On-chip oscillator clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| drop_i | input | 1 | Supply-below-threshold flag, synchronous |
| enable_i | input | 1 | Detection enable pin |
| arm_stb_i | input | 1 | Arm-in-power-down instruction strobe |
| pd_prefix_stb_i | input | 1 | Power-down prefix instruction strobe |
| pd_a_stb_i | input | 1 | First power-down instruction strobe |
| pd_b_stb_i | input | 1 | Second power-down instruction strobe |
| timer_wake_i | input | 1 | Timer wake flag |
| key_wake_i | input | 1 | Key-on wakeup pulse |
| sys_reset_o | output | 1 | Stretched internal system reset, active high |
| pd_mode_o | output | 1 | Power-down latch state |
| armed_o | output | 1 | Arm latch state |

## Verification
The bench builds the controller with RELEASE_COUNT set to 24 in place of 5412. Each release window is then short enough that one run can cover many separate windows: restarts on the window's last cycle, drops that land mid-release, and long sequences of pseudo-random strobes and wakes. The 13-bit counter width at the default comes from the same derivation that gives a 5-bit counter at 24, so the counter's terminal compare and hold are exercised the same way at the small value.

// File: rtl/svr_pkg.sv
// Shared types for the supply-drop reset controller.
// Assumes all strobes are single-cycle pulses synchronous to the oscillator clock.
package svr_pkg;

    // Decoded instruction strobes delivered by the CPU in one cycle.
    typedef struct packed {
        logic arm;
        logic prefix;
        logic pd_a;
        logic pd_b;
    } svr_cmd_t;

    // Sources that wake the CPU out of power-down.
    typedef struct packed {
        logic timer;
        logic key;
    } svr_wake_t;

endpackage

// File: rtl/svr_mode_latches.sv
// Power-down and arm latches, plus the one-cycle prefix pending flag.
// Assumes rst_int is the registered internal reset; clearing always wins over setting.
module svr_mode_latches
    import svr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rst_int,
    input  svr_cmd_t  cmd,
    input  svr_wake_t wake,
    output logic      pd_mode,
    output logic      armed,
    output logic      pend
);

    logic pd_req;
    logic pd_clr;

    // Decode a set request for power-down and the combined clear sources.
    always_comb begin
        pd_req = pend & (cmd.pd_a | cmd.pd_b);
        pd_clr = rst_int | wake.timer | wake.key;
    end

    // Remember a prefix strobe for exactly the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_int) pend <= 1'b0;
        else                   pend <= cmd.prefix;
    end

    // Power-down latch: set by prefixed power-down strobe, cleared by wake or reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      pd_mode <= 1'b0;
        else if (pd_clr) pd_mode <= 1'b0;
        else if (pd_req) pd_mode <= 1'b1;
    end

    // Arm latch: set by arm strobe, cleared only by internal reset.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_int) armed <= 1'b0;
        else if (cmd.arm)      armed <= 1'b1;
    end

endmodule

// File: rtl/svr_drop_qual.sv
// Qualifies the raw low-supply flag against the enable pin and the mode latches.
// Assumes the flag is already synchronous; no hysteresis is applied here.
module svr_drop_qual (
    input  logic drop,
    input  logic enable,
    input  logic pd_mode,
    input  logic armed,
    output logic qual
);

    // Detection counts when enabled, and in power-down only if armed.
    always_comb begin
        qual = enable & drop & (~pd_mode | armed);
    end

endmodule

// File: rtl/svr_release_timer.sv
// Holds reset while a qualified drop is present and for RELEASE_COUNT cycles after it.
// Assumes RELEASE_COUNT >= 2; the counter freezes at its terminal value once released.
module svr_release_timer #(
    parameter int RELEASE_COUNT = 5412,
    localparam int CNT_W = $clog2(RELEASE_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qual,
    output logic             rst_out,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(RELEASE_COUNT - 1);

    // Restart on every qualified drop, count out the hold time, then release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            rst_out <= 1'b1;
        end else if (qual) begin
            cnt     <= '0;
            rst_out <= 1'b1;
        end else if (rst_out) begin
            if (cnt == LAST) rst_out <= 1'b0;
            else             cnt     <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/svr_reset_ctrl.sv
// Top of the supply-drop reset controller: mode latches, drop qualifier, release timer.
// Assumes every input is synchronous to clk, the on-chip oscillator clock.
module svr_reset_ctrl
    import svr_pkg::*;
#(
    parameter int RELEASE_COUNT = 5412,
    localparam int CNT_W = $clog2(RELEASE_COUNT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drop_i,
    input  logic enable_i,
    input  logic arm_stb_i,
    input  logic pd_prefix_stb_i,
    input  logic pd_a_stb_i,
    input  logic pd_b_stb_i,
    input  logic timer_wake_i,
    input  logic key_wake_i,
    output logic sys_reset_o,
    output logic pd_mode_o,
    output logic armed_o
);

    svr_cmd_t         cmd;
    svr_wake_t        wake;
    logic             pend_w;
    logic             qual_w;
    logic [CNT_W-1:0] cnt_w;

    // Gather strobes and wake sources into their shared types.
    always_comb begin
        cmd.arm    = arm_stb_i;
        cmd.prefix = pd_prefix_stb_i;
        cmd.pd_a   = pd_a_stb_i;
        cmd.pd_b   = pd_b_stb_i;
        wake.timer = timer_wake_i;
        wake.key   = key_wake_i;
    end

    svr_mode_latches u_latches (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_int (sys_reset_o),
        .cmd     (cmd),
        .wake    (wake),
        .pd_mode (pd_mode_o),
        .armed   (armed_o),
        .pend    (pend_w)
    );

    svr_drop_qual u_qual (
        .drop    (drop_i),
        .enable  (enable_i),
        .pd_mode (pd_mode_o),
        .armed   (armed_o),
        .qual    (qual_w)
    );

    svr_release_timer #(.RELEASE_COUNT(RELEASE_COUNT)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .qual    (qual_w),
        .rst_out (sys_reset_o),
        .cnt     (cnt_w)
    );

endmodule

// File: rtl/svr_reset_ctrl_checker.sv
// Temporal checks on the supply-drop reset controller, bound into its top.
// Assumes rst_n is driven low from time zero by the environment.
module svr_reset_ctrl_checker #(
    parameter int RELEASE_COUNT = 5412,
    localparam int CNT_W = $clog2(RELEASE_COUNT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             drop_i,
    input logic             enable_i,
    input logic             timer_wake_i,
    input logic             key_wake_i,
    input logic             sys_reset_o,
    input logic             pd_mode_o,
    input logic             armed_o,
    input logic             pend_w,
    input logic [CNT_W-1:0] cnt_w
);

    AST_RUN_DROP_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && drop_i && !pd_mode_o) |=> sys_reset_o); // R3
    AST_UNARMED_PD_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_mode_o && !armed_o && !sys_reset_o) |=> !sys_reset_o); // R4
    AST_ARMED_PD_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && drop_i && pd_mode_o && armed_o) |=> sys_reset_o); // R5
    AST_DISABLED_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_i && !sys_reset_o) |=> !sys_reset_o); // R2
    AST_ARM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !sys_reset_o) |=> armed_o); // R6
    AST_PD_NEEDS_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_mode_o) |-> $past(pend_w)); // R7
    AST_WAKE_CLEARS_PD: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_wake_i || key_wake_i) |=> !pd_mode_o); // R8
    AST_RESET_CLEARS_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_o |=> (!pd_mode_o && !armed_o && !pend_w)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_w <= CNT_W'(RELEASE_COUNT - 1)); // R9

endmodule

bind svr_reset_ctrl svr_reset_ctrl_checker #(.RELEASE_COUNT(RELEASE_COUNT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drop_i       (drop_i),
    .enable_i     (enable_i),
    .timer_wake_i (timer_wake_i),
    .key_wake_i   (key_wake_i),
    .sys_reset_o  (sys_reset_o),
    .pd_mode_o    (pd_mode_o),
    .armed_o      (armed_o),
    .pend_w       (pend_w),
    .cnt_w        (cnt_w)
);

// File: tb/tb_svr_reset_ctrl.sv
// Bench: behavioural reference model compared against the controller on every clock.
module tb_svr_reset_ctrl;

    localparam int N = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic drop_i = 1'b0, enable_i = 1'b0;
    logic arm_stb_i = 1'b0, pd_prefix_stb_i = 1'b0, pd_a_stb_i = 1'b0, pd_b_stb_i = 1'b0;
    logic timer_wake_i = 1'b0, key_wake_i = 1'b0;
    logic sys_reset_o, pd_mode_o, armed_o;

    int    vectors = 0;
    int    errors  = 0;
    bit    started = 1'b0;
    bit    done    = 1'b0;
    string cur_req = "R1";

    // Reference state.
    bit m_rst, m_pd, m_arm, m_pend, m_q;
    int m_left;

    always #10 clk = ~clk;

    svr_reset_ctrl #(.RELEASE_COUNT(N)) dut (
        .clk(clk), .rst_n(rst_n), .drop_i(drop_i), .enable_i(enable_i),
        .arm_stb_i(arm_stb_i), .pd_prefix_stb_i(pd_prefix_stb_i),
        .pd_a_stb_i(pd_a_stb_i), .pd_b_stb_i(pd_b_stb_i),
        .timer_wake_i(timer_wake_i), .key_wake_i(key_wake_i),
        .sys_reset_o(sys_reset_o), .pd_mode_o(pd_mode_o), .armed_o(armed_o)
    );

    // Reference model of the requirements, advanced at every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_rst = 1; m_left = N; m_pd = 0; m_arm = 0; m_pend = 0;
        end else begin
            m_q = enable_i && drop_i && (!m_pd || m_arm);
            if (m_rst || timer_wake_i || key_wake_i) m_pd = 0;
            else if (m_pend && (pd_a_stb_i || pd_b_stb_i)) m_pd = 1;
            m_arm  = m_rst ? 0 : (m_arm || arm_stb_i);
            m_pend = m_rst ? 0 : pd_prefix_stb_i;
            if (m_q) begin
                m_rst = 1; m_left = N;
            end else if (m_rst) begin
                if (m_left <= 1) m_rst = 0;
                m_left = m_left - 1;
            end
        end
        started = 1'b1;
    end

    // Compare all outputs against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (sys_reset_o !== m_rst) begin
                errors++;
                $display("FAIL %s sys_reset_o actual=%b expected=%b t=%0t", cur_req, sys_reset_o, m_rst, $time);
            end
            if (pd_mode_o !== m_pd) begin
                errors++;
                $display("FAIL %s pd_mode_o actual=%b expected=%b t=%0t", cur_req, pd_mode_o, m_pd, $time);
            end
            if (armed_o !== m_arm) begin
                errors++;
                $display("FAIL %s armed_o actual=%b expected=%b t=%0t", cur_req, armed_o, m_arm, $time);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_release();
        for (int i = 0; i < 4 * N && sys_reset_o; i++) @(negedge clk);
        cyc(2);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int lfsr = 32'h1ACE5;
        // R1: power-on reset and exact release length.
        cur_req = "R1";
        cyc(3); rst_n = 1'b1;
        cyc(N + 4);

        // R2: enable low masks drops, running and later in armed power-down.
        cur_req = "R2";
        drop_i = 1; cyc(10); drop_i = 0; cyc(2);

        // R3: running-mode drop, one-cycle and long.
        cur_req = "R3";
        enable_i = 1; drop_i = 1; cyc(1); drop_i = 0; wait_release();
        drop_i = 1; cyc(5); drop_i = 0; wait_release();

        // R9: restart inside the release window, including its last cycle.
        cur_req = "R9";
        drop_i = 1; cyc(1); drop_i = 0; cyc(10);
        drop_i = 1; cyc(1); drop_i = 0; cyc(N - 1);
        drop_i = 1; cyc(1); drop_i = 0; wait_release();

        // R7: power-down entry needs the prefix in the immediately preceding cycle.
        cur_req = "R7";
        pd_a_stb_i = 1; cyc(1); pd_a_stb_i = 0; cyc(2);
        pd_prefix_stb_i = 1; cyc(1); pd_prefix_stb_i = 0; cyc(1);
        pd_b_stb_i = 1; cyc(1); pd_b_stb_i = 0; cyc(2);
        pd_prefix_stb_i = 1; cyc(1); pd_prefix_stb_i = 0;
        pd_b_stb_i = 1; cyc(1); pd_b_stb_i = 0; cyc(2);

        // R4: unarmed power-down ignores drops.
        cur_req = "R4";
        drop_i = 1; cyc(8); drop_i = 0; cyc(2);

        // R8: timer wake, key wake, and clear beating a same-cycle set.
        cur_req = "R8";
        timer_wake_i = 1; cyc(1); timer_wake_i = 0; cyc(2);
        pd_prefix_stb_i = 1; cyc(1); pd_prefix_stb_i = 0;
        pd_a_stb_i = 1; cyc(1); pd_a_stb_i = 0; cyc(2);
        key_wake_i = 1; cyc(1); key_wake_i = 0; cyc(2);
        pd_prefix_stb_i = 1; cyc(1); pd_prefix_stb_i = 0;
        pd_a_stb_i = 1; key_wake_i = 1; cyc(1); pd_a_stb_i = 0; key_wake_i = 0; cyc(2);

        // R6: arm latch set, survives wakes.
        cur_req = "R6";
        arm_stb_i = 1; cyc(1); arm_stb_i = 0; cyc(2);
        timer_wake_i = 1; key_wake_i = 1; cyc(1); timer_wake_i = 0; key_wake_i = 0; cyc(2);
        pd_prefix_stb_i = 1; cyc(1); pd_prefix_stb_i = 0;
        pd_b_stb_i = 1; cyc(1); pd_b_stb_i = 0; cyc(2);

        // R2 again: armed power-down with enable low still ignores drops.
        cur_req = "R2";
        enable_i = 0; drop_i = 1; cyc(6); drop_i = 0; enable_i = 1; cyc(2);

        // R5: armed power-down drop resets; R10: strobes during reset ignored.
        cur_req = "R5";
        drop_i = 1; cyc(1); drop_i = 0; cyc(2);
        cur_req = "R10";
        arm_stb_i = 1; pd_prefix_stb_i = 1; cyc(1); arm_stb_i = 0; pd_prefix_stb_i = 0;
        pd_a_stb_i = 1; cyc(1); pd_a_stb_i = 0;
        wait_release();

        // R9: pseudo-random mix of all inputs.
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            drop_i          = (lfsr[7:0] < 8'd6);
            enable_i        = (lfsr[11:8] != 4'd0);
            arm_stb_i       = (lfsr[15:12] == 4'd3);
            pd_prefix_stb_i = (lfsr[19:16] < 4'd3);
            pd_a_stb_i      = (lfsr[22:20] == 3'd1);
            pd_b_stb_i      = (lfsr[25:23] == 3'd2);
            timer_wake_i    = (lfsr[30:26] == 5'd7);
            key_wake_i      = (lfsr[30:26] == 5'd9);
            cyc(1);
        end
        drop_i = 0; arm_stb_i = 0; pd_prefix_stb_i = 0; pd_a_stb_i = 0;
        pd_b_stb_i = 0; timer_wake_i = 0; key_wake_i = 0;
        wait_release();
        finish_run();
    end

endmodule